// File: doc/BRIEF.md
# DMA Window Address Translator

This block turns a 32-bit address seen on the I/O bus into a 34-bit system memory address for device-initiated transfers. Four programmable windows are searched for each request. Each window holds three 64-bit registers: a base word, a size mask and a translation target. The base word also carries an enable flag and a mode flag. A matching window either maps the address directly, which replaces the upper bits with the translation target, or uses the address as an index into a page table in memory. In the page-table case the block issues one 64-bit read on its memory port and forms the final address from the returned entry. An address that hits no enabled window leaves the block unchanged.

Requests use a valid/ready handshake, and only one translation is in progress at a time. The window registers are loaded through a write-only configuration port. Table fetches use a request/acknowledge pair followed by a response strobe that can arrive after any number of cycles.

Top module: `dwt_translator`

## Requirements
- R1: After reset, all twelve window registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. As a result, a request made before any configuration passes through unchanged.
- R2: Window w matches address A when A and the base word of w are equal on every bit in 31:20 whose bit in the size mask of w is 0. The size mask does not affect any other compare bit.
- R3: Bit 0 of the base word enables the window. A window that matches but is not enabled is skipped, and the search goes on with the next window.
- R4: Windows are examined from index 0 upward. The lowest-indexed window that is both enabled and matching produces the result.
- R5: Direct mode (base bit 1 = 0): let M = (mask AND 0xFFF00000) OR 0xFFFFF. The result is (target AND NOT M) OR (A AND M).
- R6: Table mode (base bit 1 = 1): the entry address is (target AND NOT (((mask AND 0xFFF00000) >> 10) OR 0x3FF)) OR ((A AND ((mask AND 0xFFF00000) OR 0xFE000)) >> 10). This address appears on `mem_req_addr`, and `mem_req_valid` and the address stay stable until `mem_req_ready` is seen. Exactly one read is issued per table-mode request.
- R7: The table-mode result is ((entry AND NOT 1) << 12) OR A[12:0].
- R8: Every translated result, in either mode, is truncated to its low 34 bits.
- R9: When no enabled window matches, `rsp_addr` equals A zero-extended to 34 bits.
- R10: Direct and pass-through results appear with `rsp_valid` on the cycle after the request is accepted. A table-mode result appears on the cycle after `mem_rsp_valid`. `req_ready` is 0 from acceptance of a table-mode request until its result cycle.
- R11: Configuration writes take effect on the next clock edge. A write made while a table-mode translation is in progress changes neither that translation's entry address nor its result, only later requests.
- R12: The configuration port selects the window with `cfg_win` and the register with `cfg_field`: 0 = base word, 1 = size mask, 2 = translation target. Code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 2 | Window index of the write |
| cfg_field | input | 2 | Register select: 0 base, 1 mask, 2 target |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_addr | output | 34 | Translated system address |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepted the read |
| mem_req_addr | output | 64 | Table entry address |
| mem_rsp_valid | input | 1 | Table entry data valid |
| mem_rsp_data | input | 64 | Returned table entry |

## Verification
The hardest state to reach is a configuration write that arrives while a table fetch is still unacknowledged. To get there, the bench starts a table-mode request, keeps `mem_req_ready` low for several cycles, and rewrites that window's target during the stall. It then checks that the pending entry address stays the same and that a later request uses the new target. Priority and the skip rule need overlapping windows, some of them disabled, so the bench loads windows that cover the same address range and then turns the lower one on and off.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    localparam int WIN_COUNT   = 4;
    localparam int REG_W       = 64;
    localparam int BUS_AW      = 32;
    localparam int SYS_AW      = 34;
    localparam int CMP_LO      = 20;
    localparam int CMP_HI      = BUS_AW - 1;
    localparam int PTE_SHIFT   = 10;
    localparam int PAGE_LSB    = 13;
    localparam int IDX_BITS    = 7;
    localparam int ENTRY_SHIFT = PAGE_LSB - 1;
    localparam int EN_BIT      = 0;
    localparam int SG_BIT      = 1;

    localparam logic [REG_W-1:0] FIELD_MASK =
        ((REG_W'(1) << (CMP_HI - CMP_LO + 1)) - REG_W'(1)) << CMP_LO;
    localparam logic [REG_W-1:0] LOW_MASK  = (REG_W'(1) << CMP_LO) - REG_W'(1);
    localparam logic [REG_W-1:0] PTE_LOW   = (REG_W'(1) << PTE_SHIFT) - REG_W'(1);
    localparam logic [REG_W-1:0] IDX_FIELD =
        ((REG_W'(1) << IDX_BITS) - REG_W'(1)) << PAGE_LSB;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_XLAT = 2'd2
    } fld_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] xlat;
    } win_cfg_t;

    typedef struct packed {
        logic [REG_W-1:0]    pte;
        logic [PAGE_LSB-1:0] low;
    } pend_t;

    function automatic logic [REG_W-1:0] hi_field(input logic [REG_W-1:0] m);
        return m & FIELD_MASK;
    endfunction

    function automatic logic [REG_W-1:0] cmp_mask(input logic [REG_W-1:0] m);
        return ~m & FIELD_MASK;
    endfunction

    function automatic logic [SYS_AW-1:0] direct_map(input win_cfg_t c,
                                                     input logic [BUS_AW-1:0] a);
        logic [REG_W-1:0] am;
        logic [REG_W-1:0] r;
        am = hi_field(c.mask) | LOW_MASK;
        r  = (c.xlat & ~am) | (REG_W'(a) & am);
        return r[SYS_AW-1:0];
    endfunction

    function automatic logic [REG_W-1:0] entry_addr(input win_cfg_t c,
                                                    input logic [BUS_AW-1:0] a);
        logic [REG_W-1:0] tm;
        logic [REG_W-1:0] bm;
        tm = (hi_field(c.mask) >> PTE_SHIFT) | PTE_LOW;
        bm = hi_field(c.mask) | IDX_FIELD;
        return (c.xlat & ~tm) | ((REG_W'(a) & bm) >> PTE_SHIFT);
    endfunction

    function automatic logic [SYS_AW-1:0] table_map(input logic [REG_W-1:0] e,
                                                    input logic [PAGE_LSB-1:0] low);
        logic [REG_W-1:0] r;
        r = ((e & ~REG_W'(1)) << ENTRY_SHIFT) | REG_W'(low);
        return r[SYS_AW-1:0];
    endfunction

endpackage

// File: rtl/dwt_window_regs.sv
module dwt_window_regs
    import dwt_pkg::*;
#(
    parameter  int NUM_WIN = WIN_COUNT,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] win,
    input  logic [1:0]       fld,
    input  logic [REG_W-1:0] wdata,
    output win_cfg_t         cfg [NUM_WIN]
);

    win_cfg_t regs_q [NUM_WIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WIN; i++) regs_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (win == IDX_W'(i)) begin
                    case (fld_e'(fld))
                        FLD_BASE: regs_q[i].base <= wdata;
                        FLD_MASK: regs_q[i].mask <= wdata;
                        FLD_XLAT: regs_q[i].xlat <= wdata;
                        default:  ;
                    endcase
                end
            end
        end
    end

    assign cfg = regs_q;

endmodule

// File: rtl/dwt_window_select.sv
module dwt_window_select
    import dwt_pkg::*;
#(
    parameter  int NUM_WIN = WIN_COUNT,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  win_cfg_t          cfg [NUM_WIN],
    input  logic [BUS_AW-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    logic [NUM_WIN-1:0] live;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign live[g] = cfg[g].base[EN_BIT] &&
            (((REG_W'(addr) ^ cfg[g].base) & cmp_mask(cfg[g].mask)) == '0);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (live[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dwt_addr_calc.sv
module dwt_addr_calc
    import dwt_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [BUS_AW-1:0] addr,
    output logic              sg_mode,
    output logic [SYS_AW-1:0] direct_addr,
    output logic [REG_W-1:0]  pte_addr
);

    assign sg_mode     = cfg.base[SG_BIT];
    assign direct_addr = direct_map(cfg, addr);
    assign pte_addr    = entry_addr(cfg, addr);

endmodule

// File: rtl/dwt_translator.sv
module dwt_translator
    import dwt_pkg::*;
#(
    parameter  int NUM_WIN = WIN_COUNT,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_win,
    input  logic [1:0]        cfg_field,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_AW-1:0] req_addr,
    output logic              rsp_valid,
    output logic [SYS_AW-1:0] rsp_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [REG_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [REG_W-1:0]  mem_rsp_data
);

    win_cfg_t          cfg [NUM_WIN];
    logic              win_hit;
    logic [IDX_W-1:0]  win_idx;
    logic              sel_sg;
    logic [SYS_AW-1:0] sel_direct;
    logic [REG_W-1:0]  sel_pte;

    st_e               st_q;
    pend_t             pend_q;
    logic              rsp_valid_q;
    logic [SYS_AW-1:0] rsp_addr_q;
    logic              accept;

    dwt_window_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .win   (cfg_win),
        .fld   (cfg_field),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    dwt_window_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .cfg  (cfg),
        .addr (req_addr),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    dwt_addr_calc u_calc (
        .cfg         (cfg[win_idx]),
        .addr        (req_addr),
        .sg_mode     (sel_sg),
        .direct_addr (sel_direct),
        .pte_addr    (sel_pte)
    );

    assign accept = req_valid && (st_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            pend_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_addr_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (win_hit && sel_sg) begin
                            pend_q.pte <= sel_pte;
                            pend_q.low <= req_addr[PAGE_LSB-1:0];
                            st_q       <= ST_FETCH;
                        end else begin
                            rsp_valid_q <= 1'b1;
                            rsp_addr_q  <= win_hit ? sel_direct : SYS_AW'(req_addr);
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_addr_q  <= table_map(mem_rsp_data, pend_q.low);
                        st_q        <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign rsp_valid     = rsp_valid_q;
    assign rsp_addr      = rsp_addr_q;
    assign mem_req_valid = (st_q == ST_FETCH);
    assign mem_req_addr  = pend_q.pte;

endmodule

// File: rtl/dwt_translator_chk.sv
module dwt_translator_chk
    import dwt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [REG_W-1:0] mem_req_addr,
    input logic             mem_rsp_valid
);

    logic wait_q;

    always_ff @(posedge clk) begin
        if (rst)                                wait_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) wait_q <= 1'b1;
        else if (mem_rsp_valid)                 wait_q <= 1'b0;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_req_valid));

    p_fetch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_read_r6: assert property (@(posedge clk) disable iff (rst)
        wait_q |-> !mem_req_valid);

    p_busy_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || wait_q) |-> !req_ready);

    p_rsp_cause_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(wait_q && mem_rsp_valid)));

endmodule

bind dwt_translator dwt_translator_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/dwt_translator_test.sv
module dwt_translator_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] a;
        logic [33:0] e;
    } vec_t;

    // rows use the window set loaded in the main sequence
    localparam vec_t VECS [7] = '{
        '{a: 32'h4123_4567, e: 34'h2_1123_4567},  // R5 direct, window 0
        '{a: 32'h4FFF_FFFF, e: 34'h2_1FFF_FFFF},  // R5 top of window 0
        '{a: 32'h8001_2345, e: 34'h3_ABC1_2345},  // R8 target bits above 33 dropped
        '{a: 32'h8011_2345, e: 34'h0_8011_2345},  // R2 bit 20 differs, no hit
        '{a: 32'hC123_4567, e: 34'h0_C123_4567},  // R3 disabled window 2 skipped
        '{a: 32'h3FFF_FFFF, e: 34'h0_3FFF_FFFF},  // R9 pass-through
        '{a: 32'h0000_0000, e: 34'h0_0000_0000}   // R9 pass-through
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_field = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [33:0] rsp_addr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dwt_translator uut (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_win       (cfg_win),
        .cfg_field     (cfg_field),
        .cfg_wdata     (cfg_wdata),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_addr      (rsp_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] w, input logic [1:0] f, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = w; cfg_field = f; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_direct(input logic [31:0] a, input logic [33:0] e, input string tag);
        @(negedge clk);
        check({tag, " ready"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " rsp_addr"}, 64'(rsp_addr), 64'(e));
    endtask

    task automatic run_table(input logic [31:0] a, input logic [63:0] pte,
                             input logic [63:0] entry, input logic [33:0] e,
                             input int hold, input int lat,
                             input logic poke, input logic [63:0] poke_val,
                             input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R6 fetch issued"}, 64'(mem_req_valid), 64'd1);
        check({tag, " R6 entry addr"}, mem_req_addr, pte);
        check({tag, " R10 ready low"}, 64'(req_ready), 64'd0);
        for (int i = 0; i < hold; i++) begin
            if (poke && i == 0) begin
                cfg_we = 1'b1; cfg_win = 2'd3; cfg_field = 2'd2; cfg_wdata = poke_val;
            end
            @(negedge clk);
            cfg_we = 1'b0;
            check({tag, " R6 hold"}, 64'(mem_req_valid), 64'd1);
            check({tag, " R11 entry addr stable"}, mem_req_addr, pte);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check({tag, " R6 single read"}, 64'(mem_req_valid), 64'd0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check({tag, " R10 no early rsp"}, 64'(rsp_valid), 64'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = entry;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check({tag, " R10 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " R7 rsp_addr"}, 64'(rsp_addr), 64'(e));
        check({tag, " R10 ready back"}, 64'(req_ready), 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        run_direct(32'h0001_2345, 34'h0_0001_2345, "R1 cleared windows pass");

        // window 0: direct, compare bits 31:28
        write_cfg(2'd0, 2'd0, 64'h4000_0001);
        write_cfg(2'd0, 2'd1, 64'h0FF0_0000);
        write_cfg(2'd0, 2'd2, 64'h2_1000_0000);
        // window 1: direct, full compare, oversized target
        write_cfg(2'd1, 2'd0, 64'h8000_0001);
        write_cfg(2'd1, 2'd2, 64'hFF_ABC0_0000);
        // window 2: disabled, covers 0xC..0xF
        write_cfg(2'd2, 2'd0, 64'hC000_0000);
        write_cfg(2'd2, 2'd1, 64'h3FF0_0000);
        write_cfg(2'd2, 2'd2, 64'h1_0000_0000);
        // window 3: table mode, compare bits 31:22
        write_cfg(2'd3, 2'd0, 64'hD000_0003);
        write_cfg(2'd3, 2'd1, 64'h0030_0000);
        write_cfg(2'd3, 2'd2, 64'h1_2345_6000);
        // R12: code 3 must not disturb window 0
        write_cfg(2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);

        foreach (VECS[i]) begin
            run_direct(VECS[i].a, VECS[i].e, $sformatf("R5/R8/R2/R3/R9 row %0d", i));
        end
        run_direct(32'h4000_0010, 34'h2_1000_0010, "R12 field code 3 ignored");

        // R3 R6 R7 R8: disabled window 2 skipped, window 3 table path, stalls
        run_table(32'hD02A_BCDE, 64'h1_2345_6AA8, 64'h0123_4567, 34'h2_3456_7CDE,
                  3, 4, 1'b1, 64'h0000_8000, "R7 stalled fetch");
        // R11 new target only for later request, zero-wait memory
        run_table(32'hD02A_BCDE, 64'h0000_8AA8, 64'h3, 34'h0_0000_3CDE,
                  0, 0, 1'b0, 64'h0, "R11 later request");

        // R4 priority: window 1 now overlaps window 0
        write_cfg(2'd1, 2'd0, 64'h4000_0001);
        write_cfg(2'd1, 2'd2, 64'h0);
        run_direct(32'h4000_0123, 34'h2_1000_0123, "R4 lower index wins");
        write_cfg(2'd0, 2'd0, 64'h4000_0000);
        run_direct(32'h4000_0123, 34'h0_0000_0123, "R3 disabled 0 falls to 1");
        @(negedge clk);
        check("R10 rsp one cycle", 64'(rsp_valid), 64'd0);

        // R1 reset clears windows again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_direct(32'h4000_0123, 34'h0_4000_0123, "R1 post-reset pass");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule